// File: doc/BRIEF.md
# Per-DIMM Memory Error Statistics Counters

This block keeps error statistics for a memory controller that has three channels, each holding up to three DIMMs. Each clock cycle it can take one error event from the ECC checker. An event gives its class (corrected or uncorrected), a flag that says whether the location is known, a channel index and a DIMM index. The block keeps a corrected and an uncorrected counter for every DIMM. A second set of counters merges errors by DIMM slot number across all channels. It also keeps controller-wide totals, counters for events with no usable location, and a seconds-since-clear timer driven by a one-second tick.

Every counter is read through a single combinational read port that takes a word address. The block has no enable for reporting a given error class, so statistics always build up whatever the software does with them. A single clear input zeroes all counters and the timer together.

Top module: `memErrStats`

## Requirements
- R1: Each (channel c, DIMM d) location has its own corrected counter at address 2*(3*c+d) and its own uncorrected counter at address 2*(3*c+d)+1 (addresses 0..17). An event with the location flag high and c<3, d<3 increments only the counter of its class at that location. Class bit 0 = corrected, 1 = uncorrected.
- R2: The slot-aggregate counters sit at address 18+2*d (corrected) and 18+2*d+1 (uncorrected). They increment for a located event on DIMM number d in any channel, so events on different channels that share d go into the same counter.
- R3: The controller-wide totals sit at address 24 (corrected) and 25 (uncorrected). They increment for every accepted event of that class, whether it is located or not.
- R4: An event with the location flag low increments the no-location counter at address 26 (corrected) or 27 (uncorrected), plus its total. It leaves every per-DIMM and slot counter unchanged.
- R5: An event with the location flag high and a channel index of 3 or a DIMM index of 3 is handled exactly like an event with no location (R4).
- R6: With the clear input high at a rising edge, every counter and the seconds timer read zero after that edge. An event or tick in that same cycle is not counted. An event in the next cycle is counted normally.
- R7: The seconds counter at address 28 increments once for each cycle in which the tick input is high.
- R8: Every counter is CNT_W bits wide (32 by default). Once it reaches its all-ones value it holds that value and does not wrap.
- R9: After reset every address reads zero. Addresses 29..31 always read zero.
- R10: The read data reflects the counter contents in the same cycle as the address, and it reflects an event on the first rising edge after the event is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evValid | input | 1 | Error event present this cycle |
| evUncorr | input | 1 | Event class: 0 corrected, 1 uncorrected |
| evLocKnown | input | 1 | Channel and DIMM indices are meaningful |
| evChan | input | 2 | Channel index |
| evDimm | input | 2 | DIMM index within the channel |
| secTick | input | 1 | One-cycle pulse each second |
| clrCounters | input | 1 | Clear all counters and the timer |
| rdAddr | input | 5 | Counter read address |
| rdData | output | CNT_W | Counter value at rdAddr |

## Verification
The bench gives each channel/DIMM pair its own mix of classes, then reads all 32 addresses. If the index arithmetic is wrong, the mismatches show up in several counters at once. A slot aggregate that lost the channel merge would hold one third of its expected count. Out-of-range indices with the location flag high test the range check: a design that trusts the flag would count such an event into no DIMM counter, or into the wrong one. The bench fires a clear together with an event and a tick to confirm the clear has priority. It then pushes counters past their all-ones value with a reduced width. A counter that wraps instead of saturating would read a small value afterwards.

// File: rtl/memErrStatsPkg.sv
package memErrStatsPkg;
  localparam int NUM_CH     = 3;
  localparam int NUM_DIMM   = 3;
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) + ((NUM_CH & (NUM_CH - 1)) == 0 ? 1 : 0) : 1;
  localparam int DIMM_W     = (NUM_DIMM > 1) ? $clog2(NUM_DIMM) + ((NUM_DIMM & (NUM_DIMM - 1)) == 0 ? 1 : 0) : 1;
  localparam int NUM_LOC    = NUM_CH * NUM_DIMM;
  localparam int LOC_BASE   = 0;
  localparam int SLOT_BASE  = LOC_BASE + 2 * NUM_LOC;
  localparam int TOTAL_BASE = SLOT_BASE + 2 * NUM_DIMM;
  localparam int NOLOC_BASE = TOTAL_BASE + 2;
  localparam int SECS_ADDR  = NOLOC_BASE + 2;
  localparam int NUM_REGS   = SECS_ADDR + 1;
  localparam int ADDR_W     = $clog2(NUM_REGS);
  localparam int NUM_SLOTS  = 1 << ADDR_W;

  typedef struct packed {
    logic              clr;
    logic              tick;
    logic              incLoc;
    logic              incNoLoc;
    logic              incTotal;
    logic              uncorr;
    logic [CH_W-1:0]   ch;
    logic [DIMM_W-1:0] dimm;
  } statStrb_t;
endpackage

// File: rtl/memErrSatCnt.sv
module memErrSatCnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc && (cnt != MAXV)) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/memErrStatsCtl.sv
module memErrStatsCtl
  import memErrStatsPkg::*;
(
  input  logic              evValid,
  input  logic              evUncorr,
  input  logic              evLocKnown,
  input  logic [CH_W-1:0]   evChan,
  input  logic [DIMM_W-1:0] evDimm,
  input  logic              secTick,
  input  logic              clrCounters,
  output statStrb_t         strb
);
  logic accept;
  logic inRange;
  logic located;

  always_comb begin
    accept  = evValid && !clrCounters;
    inRange = (evChan < CH_W'(NUM_CH)) && (evDimm < DIMM_W'(NUM_DIMM));
    located = evLocKnown && inRange;

    strb          = '0;
    strb.clr      = clrCounters;
    strb.tick     = secTick && !clrCounters;
    strb.incLoc   = accept && located;
    strb.incNoLoc = accept && !located;
    strb.incTotal = accept;
    strb.uncorr   = evUncorr;
    strb.ch       = evChan;
    strb.dimm     = evDimm;
  end
endmodule

// File: rtl/memErrStatsDp.sv
module memErrStatsDp
  import memErrStatsPkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  statStrb_t         strb,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic [CNT_W-1:0]  regView [NUM_SLOTS]
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar d = 0; d < NUM_DIMM; d++) begin : g_dimm
      for (genvar k = 0; k < 2; k++) begin : g_cls
        localparam int IDX = LOC_BASE + 2 * (c * NUM_DIMM + d) + k;
        logic hit;
        assign hit = strb.incLoc && (strb.ch == CH_W'(c)) &&
                     (strb.dimm == DIMM_W'(d)) && (strb.uncorr == 1'(k));
        memErrSatCnt #(.W(CNT_W)) u_cnt (
          .clk(clk), .rstN(rstN), .clr(strb.clr), .inc(hit), .cnt(regView[IDX])
        );
      end
    end
  end

  for (genvar d = 0; d < NUM_DIMM; d++) begin : g_slot
    for (genvar k = 0; k < 2; k++) begin : g_cls
      localparam int IDX = SLOT_BASE + 2 * d + k;
      logic hit;
      assign hit = strb.incLoc && (strb.dimm == DIMM_W'(d)) && (strb.uncorr == 1'(k));
      memErrSatCnt #(.W(CNT_W)) u_cnt (
        .clk(clk), .rstN(rstN), .clr(strb.clr), .inc(hit), .cnt(regView[IDX])
      );
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_glob
    logic hitTot;
    logic hitNoLoc;
    assign hitTot   = strb.incTotal && (strb.uncorr == 1'(k));
    assign hitNoLoc = strb.incNoLoc && (strb.uncorr == 1'(k));
    memErrSatCnt #(.W(CNT_W)) u_tot (
      .clk(clk), .rstN(rstN), .clr(strb.clr), .inc(hitTot), .cnt(regView[TOTAL_BASE + k])
    );
    memErrSatCnt #(.W(CNT_W)) u_noLoc (
      .clk(clk), .rstN(rstN), .clr(strb.clr), .inc(hitNoLoc), .cnt(regView[NOLOC_BASE + k])
    );
  end

  memErrSatCnt #(.W(CNT_W)) u_secs (
    .clk(clk), .rstN(rstN), .clr(strb.clr), .inc(strb.tick), .cnt(regView[SECS_ADDR])
  );

  for (genvar a = NUM_REGS; a < NUM_SLOTS; a++) begin : g_unused
    assign regView[a] = '0;
  end

  assign rdData = regView[rdAddr];
endmodule

// File: rtl/memErrStats.sv
module memErrStats
  import memErrStatsPkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evValid,
  input  logic              evUncorr,
  input  logic              evLocKnown,
  input  logic [CH_W-1:0]   evChan,
  input  logic [DIMM_W-1:0] evDimm,
  input  logic              secTick,
  input  logic              clrCounters,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData
);
  statStrb_t        strb;
  logic [CNT_W-1:0] regView [NUM_SLOTS];

  memErrStatsCtl u_ctl (
    .evValid(evValid), .evUncorr(evUncorr), .evLocKnown(evLocKnown),
    .evChan(evChan), .evDimm(evDimm), .secTick(secTick),
    .clrCounters(clrCounters), .strb(strb)
  );

  memErrStatsDp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdAddr(rdAddr),
    .rdData(rdData), .regView(regView)
  );
endmodule

// File: rtl/memErrStatsChk.sv
module memErrStatsChk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             evValid,
  input logic             evUncorr,
  input logic             evLocKnown,
  input logic             secTick,
  input logic             clrCounters,
  input logic [CNT_W-1:0] totCe,
  input logic [CNT_W-1:0] totUe,
  input logic [CNT_W-1:0] noLocCe,
  input logic [CNT_W-1:0] noLocUe,
  input logic [CNT_W-1:0] secs
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  // R6: clear empties every global counter and the timer
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    clrCounters |=> (totCe == '0 && totUe == '0 && noLocCe == '0 && noLocUe == '0 && secs == '0));

  // R3: corrected total steps by one per accepted corrected event
  a_r3_total_ce_step: assert property (@(posedge clk) disable iff (!rstN)
    (!clrCounters && evValid && !evUncorr && totCe != MAXV) |=> totCe == CNT_W'($past(totCe) + 1'b1));

  // R3: uncorrected total holds without an uncorrected event
  a_r3_total_ue_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!clrCounters && !(evValid && evUncorr)) |=> $stable(totUe));

  // R4: unlocated corrected event reaches the no-location counter
  a_r4_noloc_ce_step: assert property (@(posedge clk) disable iff (!rstN)
    (!clrCounters && evValid && !evLocKnown && !evUncorr && noLocCe != MAXV)
      |=> noLocCe == CNT_W'($past(noLocCe) + 1'b1));

  // R8: a saturated counter stays at its maximum
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (!clrCounters && totCe == MAXV) |=> totCe == MAXV);

  // R7: each tick advances the seconds counter
  a_r7_tick_step: assert property (@(posedge clk) disable iff (!rstN)
    (!clrCounters && secTick && secs != MAXV) |=> secs == CNT_W'($past(secs) + 1'b1));
endmodule

bind memErrStats memErrStatsChk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .evValid(evValid), .evUncorr(evUncorr),
  .evLocKnown(evLocKnown), .secTick(secTick), .clrCounters(clrCounters),
  .totCe(regView[memErrStatsPkg::TOTAL_BASE]),
  .totUe(regView[memErrStatsPkg::TOTAL_BASE + 1]),
  .noLocCe(regView[memErrStatsPkg::NOLOC_BASE]),
  .noLocUe(regView[memErrStatsPkg::NOLOC_BASE + 1]),
  .secs(regView[memErrStatsPkg::SECS_ADDR])
);

// File: tb/test_memErrStats.sv
module test_memErrStats;
  localparam int W    = 4;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evValid = 1'b0, evUncorr = 1'b0, evLocKnown = 1'b0;
  logic [1:0] evChan = '0, evDimm = '0;
  logic secTick = 1'b0, clrCounters = 1'b0;
  logic [4:0] rdAddr = '0;
  logic [W-1:0] rdData;

  int errs = 0;
  int checks = 0;
  int expv [32];

  always #2 clk = ~clk;

  memErrStats #(.CNT_W(W)) i_memErrStats (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evUncorr(evUncorr),
    .evLocKnown(evLocKnown), .evChan(evChan), .evDimm(evDimm),
    .secTick(secTick), .clrCounters(clrCounters), .rdAddr(rdAddr), .rdData(rdData)
  );

  function automatic string reqOf(int a);
    if (a < 18) return "R1";
    if (a < 24) return "R2";
    if (a < 26) return "R3";
    if (a < 28) return "R4";
    if (a == 28) return "R7";
    return "R9";
  endfunction

  function automatic void bump(int idx);
    if (expv[idx] < MAXV) expv[idx] = expv[idx] + 1;
  endfunction

  function automatic void modelEv(bit u, bit loc, int ch, int d);
    if (loc && ch < 3 && d < 3) begin
      bump(2 * (3 * ch + d) + int'(u));
      bump(18 + 2 * d + int'(u));
    end else begin
      bump(26 + int'(u));
    end
    bump(24 + int'(u));
  endfunction

  task automatic checkAll(string tag);
    for (int a = 0; a < 32; a++) begin
      rdAddr = 5'(a);
      #1;
      checks++;
      if (int'(rdData) != expv[a]) begin
        errs++;
        $display("FAIL %s/%s addr %0d: actual %0d expected %0d", tag, reqOf(a), a, rdData, expv[a]);
      end
    end
  endtask

  task automatic sendEv(bit u, bit loc, int ch, int d);
    @(negedge clk);
    evValid = 1'b1; evUncorr = u; evLocKnown = loc;
    evChan = 2'(ch); evDimm = 2'(d);
    @(negedge clk);
    evValid = 1'b0;
    modelEv(u, loc, ch, d);
  endtask

  // R9: reset state, unused addresses read zero
  task automatic testReset();
    for (int a = 0; a < 32; a++) expv[a] = 0;
    checkAll("R9 reset");
  endtask

  // R1 R2 R3 R10: every location, both classes, uneven counts
  task automatic testLocated();
    for (int c = 0; c < 3; c++)
      for (int d = 0; d < 3; d++) begin
        sendEv(1'b0, 1'b1, c, d);
        sendEv(1'b1, 1'b1, c, d);
      end
    sendEv(1'b1, 1'b1, 2, 1);
    sendEv(1'b0, 1'b1, 0, 2);
    checkAll("R1 R2 R3 located");
  endtask

  // R4 R5: unlocated and out-of-range events
  task automatic testNoLoc();
    sendEv(1'b0, 1'b0, 1, 1);
    sendEv(1'b0, 1'b0, 0, 0);
    sendEv(1'b1, 1'b0, 2, 2);
    sendEv(1'b0, 1'b1, 3, 1);
    sendEv(1'b1, 1'b1, 1, 3);
    checkAll("R4 R5 noloc");
  endtask

  // R7: seconds tick
  task automatic testSecs();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); secTick = 1'b1;
      @(negedge clk); secTick = 1'b0;
      @(negedge clk);
      expv[28] = expv[28] + 1;
    end
    checkAll("R7 secs");
  endtask

  // R8: push past all-ones
  task automatic testSat();
    for (int i = 0; i < MAXV + 4; i++) sendEv(1'b0, 1'b1, 0, 0);
    for (int i = 0; i < MAXV + 2; i++) begin
      @(negedge clk); secTick = 1'b1;
      @(negedge clk); secTick = 1'b0;
      if (expv[28] < MAXV) expv[28] = expv[28] + 1;
    end
    checkAll("R8 saturate");
  endtask

  // R6: clear beats a simultaneous event and tick; next event counts
  task automatic testClear();
    @(negedge clk);
    clrCounters = 1'b1; evValid = 1'b1; evUncorr = 1'b1; evLocKnown = 1'b1;
    evChan = 2'd1; evDimm = 2'd2; secTick = 1'b1;
    @(negedge clk);
    clrCounters = 1'b0; evValid = 1'b0; secTick = 1'b0;
    for (int a = 0; a < 32; a++) expv[a] = 0;
    checkAll("R6 clear");
    sendEv(1'b1, 1'b1, 2, 0);
    checkAll("R6 after clear");
  endtask

  initial begin
    #(200000 * 4);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLocated();
    testNoLoc();
    testSecs();
    testSat();
    testClear();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule